// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches a parameterised number of asynchronous input lines and turns selected edges on them into latched per-line pending flags. Each line can be armed independently for rising edges, for falling edges, or for both, and a line with neither armed ignores its input. Software reads the pending flags and acknowledges a line by writing a one to its bit. Writing a zero to a bit has no effect on that bit.

Pending lines that are also interrupt-enabled drive a small set of registered, active-high, level-sensitive request outputs. Lines 0 to 4 each have their own request output. Lines 5 to 9 share one request output, and lines 10 to 15 share another. Lines from 16 upward can latch pending flags but drive no request output. The default line count is 19, the line count must be at least 16, and the register data width must be at least the line count.

Control and status sit behind a simple synchronous register bus. Writes take effect on the clock edge at which the select and write strobes are high. Reads are combinational and return the current register contents.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and every request output is low.
- R2: A low-to-high change on line k with its rising-enable bit set sets bit k of the pending register (offset 0xC) within four clocks.
- R3: A high-to-low change on line k with its falling-enable bit set sets pending bit k.
- R4: With both enable bits set, either edge sets the flag. With the matching enable bit clear, an edge leaves the flag at 0.
- R5: Writing 1 to pending bit k clears it, and writing 0 to bit k leaves it unchanged.
- R6: If a detected edge and a write-1 clear of the same line land in the same cycle, the pending flag stays set.
- R7: A request output is high only while at least one of its lines is both pending and interrupt-enabled. It follows a change of the enable register one clock later.
- R8: Lines 0 to 4 drive request outputs irq_o[0] to irq_o[4], one line to one bit.
- R9: irq_o[5] is the OR of enabled pending lines 5 to 9, and irq_o[6] is the OR of enabled pending lines 10 to 15.
- R10: Lines 16 and above set pending flags but drive no request output.
- R11: The registers are at offsets 0x0 (interrupt enable), 0x4 (rising enable), 0x8 (falling enable) and 0xC (pending). Enable registers read back what was written, limited to the implemented lines. Bits above the line count read 0. Writes to the pending register never set a bit.
- R12: A line held at a constant level sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | N_LINES | Asynchronous external lines |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Byte address, bits [3:2] pick the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_o | output | 7 | Request outputs: 0-4 dedicated, 5 and 6 grouped |

## Verification
Each line is driven with single rising changes, single falling changes, and full pulses. These are tried with only the rising enable set, only the falling enable set, both set, or neither set, so that a swapped or ignored edge polarity shows up in the pending bit. Two lines of a group are made pending together and then cleared one at a time, which separates an OR of the group from a single-member mapping. The clear write is timed to land in the exact cycle an edge is detected, so a design that lets the clear win is caught. A line is also held steady after its flag is cleared, so that a design detecting levels instead of edges is caught.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [1:0] {
    REG_IE   = 2'd0,
    REG_RISE = 2'd1,
    REG_FALL = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_DED  = 5;
  localparam int unsigned G1_LO    = 5;
  localparam int unsigned G1_HI    = 9;
  localparam int unsigned G2_LO    = 10;
  localparam int unsigned G2_HI    = 15;
  localparam int unsigned NUM_IRQ  = NUM_DED + 2;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned N = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise_o = sync_q & ~prev_q;
    fall_o = ~sync_q & prev_q;
  end
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned N  = 19,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  fall_i,
  output logic [N-1:0]  ie_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  set_o,
  output logic [N-1:0]  clr_o
);
  logic [N-1:0] ie_q, rise_en_q, fall_en_q, pend_q;
  logic [N-1:0] ie_d, rise_en_d, fall_en_d, pend_d;
  logic         ie_we, rise_we, fall_we, pend_we;
  logic         wr_en;
  reg_sel_e     sel;
  logic [N-1:0] wd;
  logic         unused_bus;

  assign unused_bus = ^{bus_addr[1:0], bus_wdata[DW-1:N]};

  always_comb begin
    wr_en   = bus_sel & bus_wr;
    sel     = reg_sel_e'(bus_addr[3:2]);
    wd      = bus_wdata[N-1:0];
    ie_we   = wr_en && (sel == REG_IE);
    rise_we = wr_en && (sel == REG_RISE);
    fall_we = wr_en && (sel == REG_FALL);
    pend_we = wr_en && (sel == REG_PEND);

    ie_d      = wd;
    rise_en_d = wd;
    fall_en_d = wd;

    set_o  = (rise_i & rise_en_q) | (fall_i & fall_en_q);
    clr_o  = pend_we ? wd : '0;
    pend_d = (pend_q & ~clr_o) | set_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      pend_q    <= '0;
    end else begin
      if (ie_we)   ie_q      <= ie_d;
      if (rise_we) rise_en_q <= rise_en_d;
      if (fall_we) fall_en_q <= fall_en_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel_e'(bus_addr[3:2]))
      REG_IE:   bus_rdata[N-1:0] = ie_q;
      REG_RISE: bus_rdata[N-1:0] = rise_en_q;
      REG_FALL: bus_rdata[N-1:0] = fall_en_q;
      REG_PEND: bus_rdata[N-1:0] = pend_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ie_o   = ie_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/edge_irq_map.sv
module edge_irq_map
  import edge_irq_pkg::*;
#(
  parameter int unsigned N = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       ie_i,
  input  logic [N-1:0]       pend_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [N-1:0]       act;
  logic [NUM_IRQ-1:0] irq_d, irq_q;
  logic               unused_hi;

  assign act = ie_i & pend_i;

  genvar g;
  generate
    for (g = 0; g < NUM_DED; g++) begin : g_ded
      assign irq_d[g] = act[g];
    end
  endgenerate

  assign irq_d[NUM_DED]     = |act[G1_HI:G1_LO];
  assign irq_d[NUM_DED + 1] = |act[G2_HI:G2_LO];

  generate
    if (N > G2_HI + 1) begin : g_hi
      assign unused_hi = ^act[N-1:G2_HI+1];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 19,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [N_LINES-1:0] rise, fall, ie_q, pend_q, set_vec, clr_vec;

  edge_irq_sync #(.N(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .rise_o(rise), .fall_o(fall)
  );

  edge_irq_regs #(.N(N_LINES), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rise_i(rise), .fall_i(fall),
    .ie_o(ie_q), .pend_o(pend_q), .set_o(set_vec), .clr_o(clr_vec)
  );

  edge_irq_map #(.N(N_LINES)) u_map (
    .clk(clk), .rst_n(rst_n), .ie_i(ie_q), .pend_i(pend_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int unsigned N = 19
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] set_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] pend,
  input logic [N-1:0] ie,
  input logic [6:0]   irq
);
  // R6: a detected edge always leaves its flag set, even with a clear
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  // R5: cleared bits without a coincident edge go to zero
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

  // R5: uncleared flags are held
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr_vec) & ~pend) == '0));

  // R12: no flag rises without a detected edge
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0));

  // R7: all lines masked means all requests low next cycle
  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |=> (irq == '0));

  // R8: dedicated output 0 follows its line one clock later
  p_ded0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq[0] == $past(ie[0] & pend[0])));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .pend(pend_q), .ie(ie_q), .irq(irq_o)
);

// File: tb/edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module edge_irq_ctrl_bench;
  localparam int N = 19;
  localparam logic [3:0] A_IE = 4'h0, A_RISE = 4'h4, A_FALL = 4'h8, A_PEND = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  irq_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic drive(input int k, input logic v);
    @(negedge clk);
    lines[k] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_IE, d);   chk("R1 ie", d, 0);
    rd(A_RISE, d); chk("R1 rise", d, 0);
    rd(A_FALL, d); chk("R1 fall", d, 0);
    rd(A_PEND, d); chk("R1 pend", d, 0);
    chk("R1 irq", {25'd0, irq_o}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_IE, 32'hFFFF_FFFF);   rd(A_IE, d);   chk("R11 ie mask", d, 32'h0007_FFFF);
    wr(A_RISE, 32'h0001_2345); rd(A_RISE, d); chk("R11 rise", d, 32'h0001_2345);
    wr(A_FALL, 32'h0006_A5A5); rd(A_FALL, d); chk("R11 fall", d, 32'h0006_A5A5);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, d); chk("R11 pend no set", d, 0);
    wr(A_IE, 0); wr(A_RISE, 0); wr(A_FALL, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(A_RISE, 32'h4);
    drive(2, 1'b1); rd(A_PEND, d); chk("R2 rise sets", d, 32'h4);
    chk("R7 masked irq", {25'd0, irq_o}, 0);
    wr(A_PEND, 32'h4);
    drive(2, 1'b0); rd(A_PEND, d); chk("R4 fall ignored", d, 0);
    wr(A_RISE, 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(A_FALL, 32'h8);
    drive(3, 1'b1); rd(A_PEND, d); chk("R4 rise ignored", d, 0);
    drive(3, 1'b0); rd(A_PEND, d); chk("R3 fall sets", d, 32'h8);
    wr(A_PEND, 32'h8); wr(A_FALL, 0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_RISE, 32'h2); wr(A_FALL, 32'h2);
    drive(1, 1'b1); rd(A_PEND, d); chk("R4 both rise", d, 32'h2);
    wr(A_PEND, 32'h0); rd(A_PEND, d); chk("R5 write0 keeps", d, 32'h2);
    wr(A_PEND, 32'h2); rd(A_PEND, d); chk("R5 write1 clears", d, 0);
    drive(1, 1'b0); rd(A_PEND, d); chk("R4 both fall", d, 32'h2);
    wr(A_PEND, 32'h2); wr(A_RISE, 0); wr(A_FALL, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_RISE, 32'h80);
    drive(7, 1'b1); wr(A_PEND, 32'h80);
    repeat (10) @(negedge clk);
    rd(A_PEND, d); chk("R12 steady high", d, 0);
    drive(7, 1'b0); wr(A_RISE, 0);
  endtask

  task automatic t_ded();
    for (int k = 0; k < 5; k++) begin
      wr(A_IE, 32'h1 << k); wr(A_RISE, 32'h1 << k);
      drive(k, ~lines[k]);
      if (lines[k] == 1'b0) drive(k, 1'b1);
      chk($sformatf("R8 line%0d", k), {25'd0, irq_o}, 32'h1 << k);
      wr(A_PEND, 32'h1 << k); @(negedge clk);
      chk($sformatf("R7 cleared line%0d", k), {25'd0, irq_o}, 0);
      drive(k, 1'b0);
    end
    wr(A_IE, 0); wr(A_RISE, 0);
  endtask

  task automatic t_grp();
    wr(A_IE, 32'h0000_FFE0); wr(A_RISE, 32'h0000_FFE0);
    drive(6, 1'b1); drive(8, 1'b1);
    chk("R9 group1", {25'd0, irq_o}, 32'h20);
    wr(A_PEND, 32'h40); @(negedge clk);
    chk("R9 group1 one left", {25'd0, irq_o}, 32'h20);
    wr(A_PEND, 32'h100); @(negedge clk);
    chk("R9 group1 empty", {25'd0, irq_o}, 0);
    drive(12, 1'b1);
    chk("R9 group2 line12", {25'd0, irq_o}, 32'h40);
    wr(A_PEND, 32'h1000); drive(15, 1'b1);
    chk("R9 group2 line15", {25'd0, irq_o}, 32'h40);
    drive(9, 1'b1);
    chk("R9 both groups", {25'd0, irq_o}, 32'h60);
    wr(A_PEND, 32'hFFFF); @(negedge clk);
    lines = '0; repeat (4) @(negedge clk);
    wr(A_IE, 0); wr(A_RISE, 0);
  endtask

  task automatic t_hi();
    logic [31:0] d;
    wr(A_IE, 32'h0006_0000); wr(A_RISE, 32'h0006_0000);
    drive(17, 1'b1);
    rd(A_PEND, d); chk("R10 pend line17", d, 32'h0002_0000);
    chk("R10 no irq", {25'd0, irq_o}, 0);
    wr(A_PEND, 32'h0002_0000); drive(17, 1'b0);
    wr(A_IE, 0); wr(A_RISE, 0);
  endtask

  task automatic t_ie();
    wr(A_RISE, 32'h1);
    drive(0, 1'b1);
    chk("R7 disabled", {25'd0, irq_o}, 0);
    wr(A_IE, 32'h1); @(negedge clk);
    chk("R7 enabled", {25'd0, irq_o}, 32'h1);
    wr(A_IE, 0); @(negedge clk);
    chk("R7 disabled again", {25'd0, irq_o}, 0);
    wr(A_PEND, 32'h1); drive(0, 1'b0); wr(A_RISE, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(A_RISE, 32'h10); wr(A_FALL, 32'h10);
    drive(4, 1'b1);
    @(negedge clk); lines[4] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h10;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(A_PEND, d); chk("R6 edge beats clear", d, 32'h10);
    wr(A_PEND, 32'h10); rd(A_PEND, d); chk("R5 plain clear", d, 0);
    wr(A_RISE, 0); wr(A_FALL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_regs(); t_rise(); t_fall(); t_both(); t_level();
    t_ded(); t_grp(); t_hi(); t_ie(); t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule